// File: doc/BRIEF.md
# Unified pointer aperture translator

This block turns a 64-bit shader pointer into the form the translation hardware consumes: a 48-bit virtual address and one select bit that chooses the page tables downstream. A select bit of 1 names the host (operating-system) tables and 0 names the GPU driver tables. The addressing mode comes from a dispatch-level translation bit and a pointer-width bit. Draw requests ignore both bits and always use the 64-bit driver mode.

Two programmable base/limit windows are checked against the pointer. The driver-table window rebases hits to an offset of at most 40 bits. The spare window only swaps the cache-policy type code. A pointer that no window covers falls into the default space of the mode. In 64-bit host mode, a non-canonical pointer outside every window is flagged as a fault. The result is registered in one pipeline stage behind a valid/ready handshake. The configuration is copied into a shadow only on idle cycles, so every request in a back-to-back burst sees the same settings.

Top module: `uptr_xlate`

## Requirements
- R1: Mode decode: translation bit 1 with width bit 0 selects 64-bit host mode. Translation bit 1 with width bit 1 selects 32-bit host mode. Translation bit 0 selects 64-bit driver mode whatever the width bit is.
- R2: A request with `req_is_draw` = 1 is translated in 64-bit driver mode. It therefore never reports select bit 1 and never takes a hole fault.
- R3: A window spans from {field, 16'h0000} to {field, 16'hFFFF}, both ends included. Here field is the 48-bit base or limit configuration value.
- R4: A pointer inside the driver-table window leaves with address = pointer − window base, select bit 0 and the default policy type.
- R5: When that offset is 2^40 or more, the fault bit is 1 and the address carries only the offset's low 40 bits with zeros above. An offset of 2^40 − 1 gives no fault.
- R6: A pointer covered by no window leaves with address = pointer bits [47:0] and the default policy type. The select bit is 1 in both host modes and 0 in driver mode.
- R7: In 64-bit host mode, a pointer whose bits [63:47] are neither all 0 nor all 1, and that no window covers, gives fault 1, select bit 1 and address = pointer bits [47:0].
- R8: A spare-window hit gives the spare policy type code. In 32-bit host mode the spare window never hits. A pointer in both windows is treated as a driver-table hit.
- R9: In 32-bit host mode only pointer bits [31:0] are used, zero-extended, for every compare and for the output. No hole fault is raised.
- R10: The result appears one cycle after acceptance. `req_ready` is high exactly when the output register is empty or being read. While `out_valid` is high and `out_ready` is low, the output holds still.
- R11: The configuration inputs take effect only through an edge at which no request is presented and none is held. Changes at other times do not affect requests accepted before the next such edge.
- R12: While `rst_n` is low, `out_valid` clears to 0 and the configuration shadow clears to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_host_xlate | input | 1 | Dispatch translation bit (1 = host tables by default) |
| cfg_narrow_ptr | input | 1 | Pointer-width bit (1 = 32-bit pointers) |
| cfg_tbl_base | input | 48 | Driver-table window base, address bits [63:16] |
| cfg_tbl_limit | input | 48 | Driver-table window limit, address bits [63:16] |
| cfg_spare_base | input | 48 | Spare window base, address bits [63:16] |
| cfg_spare_limit | input | 48 | Spare window limit, address bits [63:16] |
| cfg_dflt_ptype | input | 2 | Default cache-policy type code |
| cfg_spare_ptype | input | 2 | Policy type code for spare-window hits |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| req_ptr | input | 64 | Shader pointer |
| req_is_draw | input | 1 | Request comes from a draw (forces 64-bit driver mode) |
| out_valid | output | 1 | Translated result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 48 | Translated virtual address |
| out_host | output | 1 | Page-table select (1 host, 0 driver) |
| out_ptype | output | 2 | Cache-policy type code |
| out_fault | output | 1 | Hole or oversize-offset fault |

## Verification
The assertions watch the handshake on every cycle. They check that reset empties the output and that every accepted request is presented on the next cycle. They check that a stalled result does not change and that a drained stage empties when nothing new arrives. They also check that a draw request never leaves with the host select bit set. The address arithmetic cannot be seen from the ports alone, so the bench scenarios carry it. These cover the exact window edges and the one-past-limit and one-below-base pointers. They also cover hole detection in each mode, the 40-bit offset overflow, spare-window precedence and its absence in 32-bit mode, and the rule that configuration changes wait for an idle edge.

// File: rtl/uptr_pkg.sv
// Shared types for the unified pointer aperture translator.
package uptr_pkg;
    // Addressing mode after decode of the dispatch and width bits.
    typedef enum logic [1:0] {
        MODE_HOST64 = 2'd0,
        MODE_HOST32 = 2'd1,
        MODE_DRV64  = 2'd2
    } xlate_mode_e;
endpackage

// File: rtl/uptr_mode_dec.sv
// Addressing mode decoder.
// Does: maps the translation bit, the width bit and the draw flag to a mode.
// Assumes: draw requests always use driver mode; the width bit only counts
// when the translation bit is set.
module uptr_mode_dec
    import uptr_pkg::*;
(
    input  logic        host_xlate,
    input  logic        narrow_ptr,
    input  logic        is_draw,
    output xlate_mode_e mode
);
    // Purpose: priority decode, draw first, then the translation bit.
    always_comb begin
        if (is_draw || !host_xlate) begin
            mode = MODE_DRV64;
        end else if (narrow_ptr) begin
            mode = MODE_HOST32;
        end else begin
            mode = MODE_HOST64;
        end
    end
endmodule

// File: rtl/uptr_ape_cmp.sv
// Base/limit window comparator.
// Does: expands the granule-aligned base and limit fields to full addresses
// and reports whether the pointer lies in the window, both ends included.
// Assumes: base > limit means the window is empty.
module uptr_ape_cmp #(
    parameter int PTR_W  = 64,
    parameter int GRAN_W = 16,
    localparam int FLD_W = PTR_W - GRAN_W
) (
    input  logic [PTR_W-1:0] ptr,
    input  logic [FLD_W-1:0] base_fld,
    input  logic [FLD_W-1:0] limit_fld,
    output logic             hit,
    output logic [PTR_W-1:0] base_full
);
    logic [PTR_W-1:0] limit_full;

    // Purpose: pad the fields with zeros (base) and ones (limit).
    always_comb begin
        base_full  = {base_fld, {GRAN_W{1'b0}}};
        limit_full = {limit_fld, {GRAN_W{1'b1}}};
    end

    // Purpose: inclusive membership compare.
    always_comb begin
        hit = (ptr >= base_full) && (ptr <= limit_full);
    end
endmodule

// File: rtl/uptr_cfg_shadow.sv
// Configuration shadow.
// Does: copies the configuration inputs on edges where load is high and
// holds them otherwise.
// Assumes: the parent raises load only when the pipeline is idle.
module uptr_cfg_shadow #(
    parameter int FLD_W = 48,
    parameter int PT_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             in_host_xlate,
    input  logic             in_narrow_ptr,
    input  logic [FLD_W-1:0] in_tbl_base,
    input  logic [FLD_W-1:0] in_tbl_limit,
    input  logic [FLD_W-1:0] in_spare_base,
    input  logic [FLD_W-1:0] in_spare_limit,
    input  logic [PT_W-1:0]  in_dflt_ptype,
    input  logic [PT_W-1:0]  in_spare_ptype,
    output logic             sh_host_xlate,
    output logic             sh_narrow_ptr,
    output logic [FLD_W-1:0] sh_tbl_base,
    output logic [FLD_W-1:0] sh_tbl_limit,
    output logic [FLD_W-1:0] sh_spare_base,
    output logic [FLD_W-1:0] sh_spare_limit,
    output logic [PT_W-1:0]  sh_dflt_ptype,
    output logic [PT_W-1:0]  sh_spare_ptype
);
    // Purpose: clear on reset, capture on idle edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_host_xlate  <= 1'b0;
            sh_narrow_ptr  <= 1'b0;
            sh_tbl_base    <= '0;
            sh_tbl_limit   <= '0;
            sh_spare_base  <= '0;
            sh_spare_limit <= '0;
            sh_dflt_ptype  <= '0;
            sh_spare_ptype <= '0;
        end else if (load) begin
            sh_host_xlate  <= in_host_xlate;
            sh_narrow_ptr  <= in_narrow_ptr;
            sh_tbl_base    <= in_tbl_base;
            sh_tbl_limit   <= in_tbl_limit;
            sh_spare_base  <= in_spare_base;
            sh_spare_limit <= in_spare_limit;
            sh_dflt_ptype  <= in_dflt_ptype;
            sh_spare_ptype <= in_spare_ptype;
        end
    end
endmodule

// File: rtl/uptr_xlate.sv
// Unified pointer aperture translator (top).
// Does: decodes the mode and tests the pointer against the driver-table
// window (index 0) and the spare window (index 1). It rebases driver-table
// hits, picks the policy type and flags hole or oversize faults. The result
// is registered once behind valid/ready.
// Assumes: the windows do not overlap (if they do, the driver-table window
// wins). The configuration is stable around the idle edges that load it.
module uptr_xlate
    import uptr_pkg::*;
#(
    parameter int PTR_W    = 64,
    parameter int VA_W     = 48,
    parameter int VM_W     = 40,
    parameter int GRAN_W   = 16,
    parameter int NARROW_W = 32,
    parameter int PT_W     = 2,
    localparam int FLD_W   = PTR_W - GRAN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_host_xlate,
    input  logic             cfg_narrow_ptr,
    input  logic [FLD_W-1:0] cfg_tbl_base,
    input  logic [FLD_W-1:0] cfg_tbl_limit,
    input  logic [FLD_W-1:0] cfg_spare_base,
    input  logic [FLD_W-1:0] cfg_spare_limit,
    input  logic [PT_W-1:0]  cfg_dflt_ptype,
    input  logic [PT_W-1:0]  cfg_spare_ptype,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [PTR_W-1:0] req_ptr,
    input  logic             req_is_draw,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VA_W-1:0]  out_addr,
    output logic             out_host,
    output logic [PT_W-1:0]  out_ptype,
    output logic             out_fault
);
    localparam int APE_N   = 2;
    localparam int APE_TBL = 0;
    localparam int APE_SPR = 1;
    localparam int HOLE_W  = PTR_W - VA_W + 1;

    logic             sh_host_xlate;
    logic             sh_narrow_ptr;
    logic [FLD_W-1:0] sh_tbl_base;
    logic [FLD_W-1:0] sh_tbl_limit;
    logic [FLD_W-1:0] sh_spare_base;
    logic [FLD_W-1:0] sh_spare_limit;
    logic [PT_W-1:0]  sh_dflt_ptype;
    logic [PT_W-1:0]  sh_spare_ptype;
    logic             cfg_load;
    xlate_mode_e      mode;
    logic [PTR_W-1:0] eff_ptr;
    logic [FLD_W-1:0] ape_base  [APE_N];
    logic [FLD_W-1:0] ape_limit [APE_N];
    logic [PTR_W-1:0] ape_full  [APE_N];
    logic [APE_N-1:0] ape_raw;
    logic [APE_N-1:0] ape_hit;
    logic [PTR_W-1:0] tbl_offs;
    logic             offs_big;
    logic [HOLE_W-1:0] top_bits;
    logic             in_hole;
    logic [VA_W-1:0]  nx_addr;
    logic             nx_host;
    logic [PT_W-1:0]  nx_ptype;
    logic             nx_fault;

    // Purpose: the shadow loads only when nothing is presented or held.
    always_comb begin
        cfg_load = !req_valid && !out_valid;
    end

    uptr_cfg_shadow #(
        .FLD_W (FLD_W),
        .PT_W  (PT_W)
    ) i_shadow (
        .clk            (clk),
        .rst_n          (rst_n),
        .load           (cfg_load),
        .in_host_xlate  (cfg_host_xlate),
        .in_narrow_ptr  (cfg_narrow_ptr),
        .in_tbl_base    (cfg_tbl_base),
        .in_tbl_limit   (cfg_tbl_limit),
        .in_spare_base  (cfg_spare_base),
        .in_spare_limit (cfg_spare_limit),
        .in_dflt_ptype  (cfg_dflt_ptype),
        .in_spare_ptype (cfg_spare_ptype),
        .sh_host_xlate  (sh_host_xlate),
        .sh_narrow_ptr  (sh_narrow_ptr),
        .sh_tbl_base    (sh_tbl_base),
        .sh_tbl_limit   (sh_tbl_limit),
        .sh_spare_base  (sh_spare_base),
        .sh_spare_limit (sh_spare_limit),
        .sh_dflt_ptype  (sh_dflt_ptype),
        .sh_spare_ptype (sh_spare_ptype)
    );

    uptr_mode_dec i_mode (
        .host_xlate (sh_host_xlate),
        .narrow_ptr (sh_narrow_ptr),
        .is_draw    (req_is_draw),
        .mode       (mode)
    );

    // Purpose: 32-bit mode keeps only the low pointer bits, zero-extended.
    always_comb begin
        if (mode == MODE_HOST32) begin
            eff_ptr = {{(PTR_W-NARROW_W){1'b0}}, req_ptr[NARROW_W-1:0]};
        end else begin
            eff_ptr = req_ptr;
        end
    end

    // Purpose: gather the window fields into indexed arrays.
    always_comb begin
        ape_base[APE_TBL]  = sh_tbl_base;
        ape_limit[APE_TBL] = sh_tbl_limit;
        ape_base[APE_SPR]  = sh_spare_base;
        ape_limit[APE_SPR] = sh_spare_limit;
    end

    // One comparator per window.
    for (genvar g = 0; g < APE_N; g++) begin : g_ape
        uptr_ape_cmp #(
            .PTR_W  (PTR_W),
            .GRAN_W (GRAN_W)
        ) i_cmp (
            .ptr       (eff_ptr),
            .base_fld  (ape_base[g]),
            .limit_fld (ape_limit[g]),
            .hit       (ape_raw[g]),
            .base_full (ape_full[g])
        );
    end

    // Purpose: the spare window does not exist in 32-bit mode.
    always_comb begin
        ape_hit[APE_TBL] = ape_raw[APE_TBL];
        ape_hit[APE_SPR] = ape_raw[APE_SPR] && (mode != MODE_HOST32);
    end

    // Purpose: rebase against the driver-table window and test the 40-bit fit.
    always_comb begin
        tbl_offs = eff_ptr - ape_full[APE_TBL];
        offs_big = |tbl_offs[PTR_W-1:VM_W];
    end

    // Purpose: canonical-hole test, 64-bit host mode only, outside every window.
    always_comb begin
        top_bits = eff_ptr[PTR_W-1:VA_W-1];
        in_hole  = (mode == MODE_HOST64)
                && (top_bits != '0) && (top_bits != '1)
                && (ape_hit == '0);
    end

    // Purpose: build the result; the driver-table window takes priority.
    always_comb begin
        nx_addr  = eff_ptr[VA_W-1:0];
        nx_host  = (mode != MODE_DRV64);
        nx_ptype = sh_dflt_ptype;
        nx_fault = in_hole;
        if (ape_hit[APE_TBL]) begin
            nx_addr  = {{(VA_W-VM_W){1'b0}}, tbl_offs[VM_W-1:0]};
            nx_host  = 1'b0;
            nx_fault = offs_big;
        end else if (ape_hit[APE_SPR]) begin
            nx_ptype = sh_spare_ptype;
        end
    end

    // Purpose: accept when the output register is empty or being drained.
    always_comb begin
        req_ready = !out_valid || out_ready;
    end

    // Purpose: single output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_host  <= 1'b0;
            out_ptype <= '0;
            out_fault <= 1'b0;
        end else if (req_ready) begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_addr  <= nx_addr;
                out_host  <= nx_host;
                out_ptype <= nx_ptype;
                out_fault <= nx_fault;
            end
        end
    end
endmodule

// File: rtl/uptr_xlate_chk.sv
// Handshake and mode checker for uptr_xlate, attached by bind.
// Does: watches the ports for reset, latency, stall and draw-mode rules.
// Assumes: rst_n is synchronous and active low.
module uptr_xlate_chk #(
    parameter int VA_W = 48,
    parameter int PT_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            req_is_draw,
    input logic            out_valid,
    input logic            out_ready,
    input logic [VA_W-1:0] out_addr,
    input logic            out_host,
    input logic [PT_W-1:0] out_ptype,
    input logic            out_fault
);
    // Reset empties the output stage (R12).
    p_reset_idle_r12: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // An accepted request is presented on the next cycle (R10).
    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> out_valid);

    // A stalled result holds still (R10).
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr)
            && $stable(out_host) && $stable(out_ptype) && $stable(out_fault));

    // A drained stage empties when nothing new arrives (R10).
    p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !req_valid |=> !out_valid);

    // Draw requests never select the host tables (R2).
    p_draw_drv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_is_draw |=> !out_host);
endmodule

bind uptr_xlate uptr_xlate_chk #(
    .VA_W (VA_W),
    .PT_W (PT_W)
) i_uptr_xlate_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_is_draw (req_is_draw),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_addr    (out_addr),
    .out_host    (out_host),
    .out_ptype   (out_ptype),
    .out_fault   (out_fault)
);

// File: tb/test_uptr_xlate.sv
`timescale 1ns/1ps
module test_uptr_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_host_xlate = 1'b0;
    logic        cfg_narrow_ptr = 1'b0;
    logic [47:0] cfg_tbl_base = '0;
    logic [47:0] cfg_tbl_limit = '0;
    logic [47:0] cfg_spare_base = '0;
    logic [47:0] cfg_spare_limit = '0;
    logic [1:0]  cfg_dflt_ptype = '0;
    logic [1:0]  cfg_spare_ptype = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_ptr = '0;
    logic        req_is_draw = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [47:0] out_addr;
    logic        out_host;
    logic [1:0]  out_ptype;
    logic        out_fault;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uptr_xlate i_uptr_xlate (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_host_xlate  (cfg_host_xlate),
        .cfg_narrow_ptr  (cfg_narrow_ptr),
        .cfg_tbl_base    (cfg_tbl_base),
        .cfg_tbl_limit   (cfg_tbl_limit),
        .cfg_spare_base  (cfg_spare_base),
        .cfg_spare_limit (cfg_spare_limit),
        .cfg_dflt_ptype  (cfg_dflt_ptype),
        .cfg_spare_ptype (cfg_spare_ptype),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_ptr         (req_ptr),
        .req_is_draw     (req_is_draw),
        .out_valid       (out_valid),
        .out_ready       (out_ready),
        .out_addr        (out_addr),
        .out_host        (out_host),
        .out_ptype       (out_ptype),
        .out_fault       (out_fault)
    );

    typedef struct packed {
        logic [7:0]  rq;
        logic        hs;
        logic        nw;
        logic        dr;
        logic [63:0] ptr;
        logic [47:0] ea;
        logic        eh;
        logic [1:0]  ep;
        logic        ef;
    } vec_t;

    localparam int NV = 17;
    // Window setup: driver-table 0x0001_0000_0000_0000..0x0001_00FF_FFFF_FFFF,
    // spare 0x7000_0000..0x7000_FFFF, default type 1, spare type 2.
    localparam vec_t VECS [NV] = '{
        '{8'd3, 1'b1, 1'b0, 1'b0, 64'h0001_0000_0000_0000, 48'h0000_0000_0000, 1'b0, 2'd1, 1'b0}, // R3 base
        '{8'd3, 1'b1, 1'b0, 1'b0, 64'h0001_00FF_FFFF_FFFF, 48'h00FF_FFFF_FFFF, 1'b0, 2'd1, 1'b0}, // R3 limit
        '{8'd7, 1'b1, 1'b0, 1'b0, 64'h0001_0100_0000_0000, 48'h0100_0000_0000, 1'b1, 2'd1, 1'b1}, // R7 limit+1
        '{8'd7, 1'b1, 1'b0, 1'b0, 64'h0000_FFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF, 1'b1, 2'd1, 1'b1}, // R7 base-1
        '{8'd6, 1'b1, 1'b0, 1'b0, 64'h0000_1234_5678_9ABC, 48'h1234_5678_9ABC, 1'b1, 2'd1, 1'b0}, // R6 low
        '{8'd6, 1'b1, 1'b0, 1'b0, 64'hFFFF_8000_0000_0010, 48'h8000_0000_0010, 1'b1, 2'd1, 1'b0}, // R6 high
        '{8'd8, 1'b1, 1'b0, 1'b0, 64'h0000_0000_7000_0000, 48'h0000_7000_0000, 1'b1, 2'd2, 1'b0}, // R8 base
        '{8'd8, 1'b1, 1'b0, 1'b0, 64'h0000_0000_7000_FFFF, 48'h0000_7000_FFFF, 1'b1, 2'd2, 1'b0}, // R8 limit
        '{8'd8, 1'b1, 1'b0, 1'b0, 64'h0000_0000_7001_0000, 48'h0000_7001_0000, 1'b1, 2'd1, 1'b0}, // R8 past
        '{8'd1, 1'b0, 1'b1, 1'b0, 64'h0000_1234_5678_9ABC, 48'h1234_5678_9ABC, 1'b0, 2'd1, 1'b0}, // R1 width ignored
        '{8'd1, 1'b0, 1'b0, 1'b0, 64'h0100_0000_0000_0ABC, 48'h0000_0000_0ABC, 1'b0, 2'd1, 1'b0}, // R1 no hole
        '{8'd4, 1'b0, 1'b0, 1'b0, 64'h0001_0000_0000_1000, 48'h0000_0000_1000, 1'b0, 2'd1, 1'b0}, // R4 driver mode
        '{8'd8, 1'b0, 1'b0, 1'b0, 64'h0000_0000_7000_0040, 48'h0000_7000_0040, 1'b0, 2'd2, 1'b0}, // R8 driver mode
        '{8'd9, 1'b1, 1'b1, 1'b0, 64'hFFFF_FFFF_7000_0010, 48'h0000_7000_0010, 1'b1, 2'd1, 1'b0}, // R9 no spare
        '{8'd9, 1'b1, 1'b1, 1'b0, 64'h0001_0000_0000_0000, 48'h0000_0000_0000, 1'b1, 2'd1, 1'b0}, // R9 upper dropped
        '{8'd2, 1'b1, 1'b0, 1'b1, 64'h0100_0000_0000_0ABC, 48'h0000_0000_0ABC, 1'b0, 2'd1, 1'b0}, // R2 draw host64
        '{8'd2, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_7000_0010, 48'hFFFF_7000_0010, 1'b0, 2'd1, 1'b0}  // R2 draw host32
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive configuration, then let at least one idle edge load it.
    task automatic set_cfg(input logic hs, input logic nw, input logic [47:0] tb,
                           input logic [47:0] tl);
        @(negedge clk);
        cfg_host_xlate = hs;
        cfg_narrow_ptr = nw;
        cfg_tbl_base   = tb;
        cfg_tbl_limit  = tl;
        repeat (3) @(negedge clk);
    endtask

    // Present one request with out_ready high; returns at the negedge after acceptance.
    task automatic send(input logic [63:0] p, input logic dr);
        @(negedge clk);
        req_ptr     = p;
        req_is_draw = dr;
        req_valid   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid   = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cfg_spare_base  = 48'h0000_0000_7000;
        cfg_spare_limit = 48'h0000_0000_7000;
        cfg_dflt_ptype  = 2'd1;
        cfg_spare_ptype = 2'd2;
        repeat (4) @(negedge clk);
        // R12: outputs idle during and right after reset
        check("R12 out_valid in reset", {63'b0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 out_valid after reset", {63'b0, out_valid}, 64'd0);
        check("R10 req_ready when empty", {63'b0, req_ready}, 64'd1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            set_cfg(VECS[i].hs, VECS[i].nw, 48'h0001_0000_0000, 48'h0001_00FF_FFFF);
            send(VECS[i].ptr, VECS[i].dr);
            check($sformatf("R%0d vec%0d valid", VECS[i].rq, i), {63'b0, out_valid}, 64'd1);
            check($sformatf("R%0d vec%0d addr", VECS[i].rq, i), {16'b0, out_addr}, {16'b0, VECS[i].ea});
            check($sformatf("R%0d vec%0d host", VECS[i].rq, i), {63'b0, out_host}, {63'b0, VECS[i].eh});
            check($sformatf("R%0d vec%0d ptype", VECS[i].rq, i), {62'b0, out_ptype}, {62'b0, VECS[i].ep});
            check($sformatf("R%0d vec%0d fault", VECS[i].rq, i), {63'b0, out_fault}, {63'b0, VECS[i].ef});
        end

        // R5: offset width; window 0x1_0000..0x0000_7FFF_FFFF_FFFF
        set_cfg(1'b1, 1'b0, 48'h0000_0000_0001, 48'h0000_7FFF_FFFF);
        send(64'h0000_0100_0001_0000, 1'b0);
        check("R5 offset 2^40 fault", {63'b0, out_fault}, 64'd1);
        check("R5 offset 2^40 addr", {16'b0, out_addr}, 64'd0);
        check("R5 offset 2^40 host", {63'b0, out_host}, 64'd0);
        send(64'h0000_0100_0000_FFFF, 1'b0);
        check("R5 offset max fault", {63'b0, out_fault}, 64'd0);
        check("R5 offset max addr", {16'b0, out_addr}, 64'h0000_00FF_FFFF_FFFF);
        // R8: pointer in both windows counts as a driver-table hit
        send(64'h0000_0000_7000_0000, 1'b0);
        check("R8 precedence addr", {16'b0, out_addr}, 64'h0000_0000_6FFF_0000);
        check("R8 precedence ptype", {62'b0, out_ptype}, 64'd1);
        check("R8 precedence host", {63'b0, out_host}, 64'd0);
        // R9: 32-bit view reaches the driver-table window
        set_cfg(1'b1, 1'b1, 48'h0000_0000_0001, 48'h0000_7FFF_FFFF);
        send(64'hABCD_0000_0001_0005, 1'b0);
        check("R9 narrow hit addr", {16'b0, out_addr}, 64'd5);
        check("R9 narrow hit host", {63'b0, out_host}, 64'd0);

        // R10: backpressure
        set_cfg(1'b1, 1'b0, 48'h0001_0000_0000, 48'h0001_00FF_FFFF);
        @(negedge clk);
        out_ready = 1'b0;
        req_ptr   = 64'h0000_0000_0000_1111;
        req_is_draw = 1'b0;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_ptr = 64'h0000_0000_0000_2222;
        check("R10 first result", {16'b0, out_addr}, 64'h1111);
        check("R10 ready low when stalled", {63'b0, req_ready}, 64'd0);
        @(posedge clk);
        @(negedge clk);
        check("R10 held result", {16'b0, out_addr}, 64'h1111);
        check("R10 held valid", {63'b0, out_valid}, 64'd1);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 second result", {16'b0, out_addr}, 64'h2222);
        repeat (2) @(negedge clk);
        check("R10 drained", {63'b0, out_valid}, 64'd0);

        // R11: config change during a busy burst waits for an idle edge
        out_ready   = 1'b0;
        req_ptr     = 64'h0001_0000_0000_0020;
        req_valid   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_tbl_base = 48'h0001_0000_0001;
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 burst keeps old base addr", {16'b0, out_addr}, 64'h20);
        check("R11 burst keeps old base fault", {63'b0, out_fault}, 64'd0);
        repeat (3) @(negedge clk);
        send(64'h0001_0000_0000_0020, 1'b0);
        check("R11 new base after idle fault", {63'b0, out_fault}, 64'd1);
        check("R11 new base after idle host", {63'b0, out_host}, 64'd1);

        // R12: reset mid-flight clears the output
        @(negedge clk);
        req_ptr   = 64'h0000_0000_0000_3333;
        req_valid = 1'b1;
        out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R12 reset clears valid", {63'b0, out_valid}, 64'd0);
        rst_n = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule